// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display pipe: a line sync, a frame sync, a display-enable strobe, and pulses that mark the start of every line and of every frame. Position is not kept in binary counters. Each axis holds a 16-bit maximal-length shift register with XOR feedback, which advances once per step and needs only one XOR level of next-state logic. Every timing event fires when the register state equals a programmed comparator word. Software converts each binary count into the register state reached after that many steps from all ones. The block only compares states.

The horizontal register steps every clock. The vertical register steps once per line, when the horizontal register wraps. Each of the four windows (line sync, frame sync, horizontal active, vertical active) is a sticky flag. A matching "on" state sets it and a matching "off" state clears it. An 8-bit blanking control can quiet the outputs while timing keeps running, or power the raster down. Power-down holds the counters and lasts until a new mode is loaded.

Top module: `lfsr_raster_timing`

## Requirements
- R1: Each position register starts from 0xFFFF after reset and after a restart. Each step shifts it left by one place and fills bit 0 with the XOR of the old bits 15, 4, 2 and 1. A programmed count N is the state reached after N steps.
- R2: The horizontal register reloads 0xFFFF on the clock after it equals `h_end_cmp`. A line is therefore N+1 clocks long when `h_end_cmp` encodes N, which is the total line length minus one.
- R3: The vertical register steps once per line. A frame is V lines long when `v_end_cmp` encodes V, the total number of lines. Line count 0 is the first line after the wrap.
- R4: `hsync` is high, one clock after the horizontal count, for counts from the `hs_on_cmp` count up to, but not including, the `hs_off_cmp` count.
- R5: `vsync` is high for line counts from the `vs_on_cmp` count up to, but not including, the `vs_off_cmp` count. It has the same one-clock latency.
- R6: `disp_en` is high when the horizontal count lies in [h_act_on, h_act_off) and the line count lies in [v_act_on, v_act_off). It has the same latency.
- R7: `line_start` pulses for the horizontal count 0 of every line. `frame_start` pulses for horizontal count 0 of line count 0, and it never pulses without `line_start`.
- R8: When `blank_mode` is nonzero and not 0x07 (0x01 is the normal screen-blank code), `hsync`, `vsync` and `disp_en` stay low. The counters keep running and `line_start` keeps pulsing. `blank_mode` 0x00 gives normal output.
- R9: `blank_mode` 0x07 enters power-down. All outputs go low and both counters are held at count 0. The state persists after `blank_mode` returns to 0x00, until a `mode_load` pulse.
- R10: A `mode_load` pulse restarts both counters at count 0, with all outputs low for that clock. Timing then proceeds exactly as it does after reset.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | One-clock pulse: restart timing and leave power-down |
| blank_mode | input | 8 | 0x00 normal, 0x07 power-down, any other value blank |
| h_end_cmp | input | 16 | Horizontal end state (total minus one) |
| hs_on_cmp | input | 16 | Line sync start state |
| hs_off_cmp | input | 16 | Line sync stop state |
| h_act_on_cmp | input | 16 | Horizontal active start state |
| h_act_off_cmp | input | 16 | Horizontal active stop state |
| v_end_cmp | input | 16 | Vertical end state (total lines) |
| vs_on_cmp | input | 16 | Frame sync start state |
| vs_off_cmp | input | 16 | Frame sync stop state |
| v_act_on_cmp | input | 16 | Vertical active start state |
| v_act_off_cmp | input | 16 | Vertical active stop state |
| hsync | output | 1 | Line sync, active high |
| vsync | output | 1 | Frame sync, active high |
| disp_en | output | 1 | Display enable |
| line_start | output | 1 | Pulse at count 0 of each line |
| frame_start | output | 1 | Pulse at count 0 of line 0 |

## Verification
Two raster geometries with different totals, sync widths and porches are compared clock by clock against a binary-count model. Each comparator word is produced by stepping the shift register in the bench. A wrong tap, a wrong seed or an off-by-one wrap therefore shows up as a shifted window or a wrong line or frame period. Blank mode is tried on its own, to show that the syncs stop while line pulses continue. Power-down is followed by a return of the control to 0x00 without a reload, to show that the latch holds. A reload issued in mid-frame shows that both counters restart from zero.

// File: rtl/lvt_pkg.sv
// Package: shared constants and the shift-register step for the raster timing block.
// Assumes 16-bit position registers with a fixed maximal-length tap set.
package lvt_pkg;
    localparam int unsigned LW = 16;
    localparam logic [LW-1:0] SEED = {LW{1'b1}};

    localparam logic [7:0] BLK_NONE  = 8'h00;
    localparam logic [7:0] BLK_PWRDN = 8'h07;

    // One step: shift left, feed back the XOR of bits 15, 4, 2 and 1.
    function automatic logic [LW-1:0] lfsr_advance(input logic [LW-1:0] s);
        return {s[LW-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction
endpackage

// File: rtl/lvt_lfsr_counter.sv
// Module: one position register with an end-state comparator.
// WRAP_ON_NEXT=0 reloads after the state equal to end_cmp has been held.
// WRAP_ON_NEXT=1 reloads in place of stepping into end_cmp, so the period equals the programmed count.
// Assumes end_cmp is reachable from SEED within the intended period.
module lvt_lfsr_counter
    import lvt_pkg::*;
#(
    parameter bit WRAP_ON_NEXT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [LW-1:0] end_cmp,
    output logic [LW-1:0] state,
    output logic          wrap
);
    logic [LW-1:0] nxt;
    logic          at_end;

    assign nxt = lfsr_advance(state);

    generate
        if (WRAP_ON_NEXT) begin : g_next
            assign at_end = (nxt == end_cmp);
        end else begin : g_curr
            assign at_end = (state == end_cmp);
        end
    endgenerate

    assign wrap = step & at_end;

    // Position register: seed on reset or restart, reload at the end, step otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= SEED;
        else if (restart) state <= SEED;
        else if (step)    state <= at_end ? SEED : nxt;
    end

    // R1
    no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    // R1
    restart_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> state == SEED);
endmodule

// File: rtl/lvt_window.sv
// Module: sticky window flag. A matching on-state sets it and a matching off-state clears it.
// win_nxt is the flag value for the current position. Assumes on_cmp != off_cmp.
module lvt_window
    import lvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [LW-1:0] pos,
    input  logic [LW-1:0] on_cmp,
    input  logic [LW-1:0] off_cmp,
    output logic          win_nxt
);
    logic flag;

    // Window value for the current position.
    always_comb begin
        if (pos == on_cmp)       win_nxt = 1'b1;
        else if (pos == off_cmp) win_nxt = 1'b0;
        else                     win_nxt = flag;
    end

    // Remember the window state between matches.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag <= 1'b0;
        else                 flag <= win_nxt;
    end
endmodule

// File: rtl/lfsr_raster_timing.sv
// Module: raster timing top. Horizontal and vertical shift-register counters drive
// four window flags, and registered, active-high outputs are gated by the blanking control.
// Assumes all comparator words are states within their axis period.
module lfsr_raster_timing
    import lvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_load,
    input  logic [7:0]    blank_mode,
    input  logic [LW-1:0] h_end_cmp,
    input  logic [LW-1:0] hs_on_cmp,
    input  logic [LW-1:0] hs_off_cmp,
    input  logic [LW-1:0] h_act_on_cmp,
    input  logic [LW-1:0] h_act_off_cmp,
    input  logic [LW-1:0] v_end_cmp,
    input  logic [LW-1:0] vs_on_cmp,
    input  logic [LW-1:0] vs_off_cmp,
    input  logic [LW-1:0] v_act_on_cmp,
    input  logic [LW-1:0] v_act_off_cmp,
    output logic          hsync,
    output logic          vsync,
    output logic          disp_en,
    output logic          line_start,
    output logic          frame_start
);
    localparam int unsigned NWIN = 4;   // 0 hsync, 1 h active, 2 vsync, 3 v active
    localparam int unsigned FIRST_V = 2;

    logic [LW-1:0] h_state, v_state;
    logic          h_wrap, v_wrap;
    logic          pd_q, pd_act, restart, blank;
    logic [LW-1:0] on_cmps  [NWIN];
    logic [LW-1:0] off_cmps [NWIN];
    logic [NWIN-1:0] win_nxt;

    // Blanking control decode: power-down is latched, restart covers reload and power-down.
    assign pd_act  = (blank_mode == BLK_PWRDN) | pd_q;
    assign restart = mode_load | pd_act;
    assign blank   = (blank_mode != BLK_NONE) | pd_act;

    lvt_lfsr_counter #(.WRAP_ON_NEXT(1'b0)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(1'b1),
        .end_cmp(h_end_cmp), .state(h_state), .wrap(h_wrap)
    );

    lvt_lfsr_counter #(.WRAP_ON_NEXT(1'b1)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(h_wrap),
        .end_cmp(v_end_cmp), .state(v_state), .wrap(v_wrap)
    );

    // Comparator table for the window flags.
    always_comb begin
        on_cmps[0] = hs_on_cmp;    off_cmps[0] = hs_off_cmp;
        on_cmps[1] = h_act_on_cmp; off_cmps[1] = h_act_off_cmp;
        on_cmps[2] = vs_on_cmp;    off_cmps[2] = vs_off_cmp;
        on_cmps[3] = v_act_on_cmp; off_cmps[3] = v_act_off_cmp;
    end

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        lvt_window u_win (
            .clk(clk), .rst_n(rst_n), .clear(restart),
            .pos((i >= FIRST_V) ? v_state : h_state),
            .on_cmp(on_cmps[i]), .off_cmp(off_cmps[i]),
            .win_nxt(win_nxt[i])
        );
    end

    // Power-down latch and registered timing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q        <= 1'b0;
            hsync       <= 1'b0;
            vsync       <= 1'b0;
            disp_en     <= 1'b0;
            line_start  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            pd_q <= (blank_mode == BLK_PWRDN) | (pd_q & ~mode_load);
            if (restart) begin
                hsync       <= 1'b0;
                vsync       <= 1'b0;
                disp_en     <= 1'b0;
                line_start  <= 1'b0;
                frame_start <= 1'b0;
            end else begin
                hsync       <= win_nxt[0] & ~blank;
                vsync       <= win_nxt[2] & ~blank;
                disp_en     <= win_nxt[1] & win_nxt[3] & ~blank;
                line_start  <= (h_state == SEED);
                frame_start <= (h_state == SEED) && (v_state == SEED);
            end
        end
    end

    // R8
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(blank_mode) != BLK_NONE) |-> (!hsync && !vsync && !disp_en));
    // R9
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |-> (!hsync && !vsync && !disp_en && !line_start));
    // R7
    frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);
    // R10
    reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_load) |-> (!line_start && !frame_start && !hsync));
    // R3
    vwrap_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |-> h_wrap);
endmodule

// File: tb/tb_lfsr_raster_timing.sv
`timescale 1ns/1ps
module tb_lfsr_raster_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [7:0]  blank_mode = 8'h00;
    logic [15:0] h_end_cmp, hs_on_cmp, hs_off_cmp, h_act_on_cmp, h_act_off_cmp;
    logic [15:0] v_end_cmp, vs_on_cmp, vs_off_cmp, v_act_on_cmp, v_act_off_cmp;
    logic        hsync, vsync, disp_en, line_start, frame_start;

    always #2.5 clk = ~clk;

    lfsr_raster_timing dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .blank_mode(blank_mode),
        .h_end_cmp(h_end_cmp), .hs_on_cmp(hs_on_cmp), .hs_off_cmp(hs_off_cmp),
        .h_act_on_cmp(h_act_on_cmp), .h_act_off_cmp(h_act_off_cmp),
        .v_end_cmp(v_end_cmp), .vs_on_cmp(vs_on_cmp), .vs_off_cmp(vs_off_cmp),
        .v_act_on_cmp(v_act_on_cmp), .v_act_off_cmp(v_act_off_cmp),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .line_start(line_start), .frame_start(frame_start)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // Binary geometry, used by the model
    int g_htot, g_hs_on, g_hs_off, g_ha_on, g_ha_off;
    int g_vtot, g_vs_on, g_vs_off, g_va_on, g_va_off;

    // Count-to-state conversion, done independently in the bench
    function automatic logic [15:0] lstate(int n);
        logic [15:0] v = 16'hFFFF;
        for (int k = 0; k < n; k++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
        return v;
    endfunction

    // Reference model in binary counts
    int hc, vc;
    bit pdm, e_hs, e_vs, e_de, e_ls, e_fs;
    always @(posedge clk) begin
        bit pda, rs, blk;
        if (!rst_n) begin
            hc = 0; vc = 0; pdm = 0;
            e_hs = 0; e_vs = 0; e_de = 0; e_ls = 0; e_fs = 0;
        end else begin
            pda = (blank_mode == 8'h07) || pdm;
            rs  = mode_load || pda;
            blk = (blank_mode != 8'h00) || pda;
            pdm = (blank_mode == 8'h07) || (pdm && !mode_load);
            if (rs) begin
                hc = 0; vc = 0;
                e_hs = 0; e_vs = 0; e_de = 0; e_ls = 0; e_fs = 0;
            end else begin
                e_hs = (hc >= g_hs_on && hc < g_hs_off) && !blk;
                e_vs = (vc >= g_vs_on && vc < g_vs_off) && !blk;
                e_de = (hc >= g_ha_on && hc < g_ha_off) &&
                       (vc >= g_va_on && vc < g_va_off) && !blk;
                e_ls = (hc == 0);
                e_fs = (hc == 0) && (vc == 0);
                if (hc == g_htot - 1) begin
                    hc = 0;
                    vc = (vc + 1 == g_vtot) ? 0 : vc + 1;
                end else hc = hc + 1;
            end
        end
    end

    task automatic cmp_run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nchk++;
            if ({hsync, vsync, disp_en, line_start, frame_start} !=
                {e_hs, e_vs, e_de, e_ls, e_fs}) begin
                nerr++;
                $display("FAIL %s cyc%0d {hs,vs,de,ls,fs} act %b%b%b%b%b exp %b%b%b%b%b",
                         tag, i, hsync, vsync, disp_en, line_start, frame_start,
                         e_hs, e_vs, e_de, e_ls, e_fs);
            end
        end
    endtask

    task automatic set_geom(int ht, int hson, int hsoff, int haon, int haoff,
                            int vt, int vson, int vsoff, int vaon, int vaoff);
        g_htot = ht; g_hs_on = hson; g_hs_off = hsoff; g_ha_on = haon; g_ha_off = haoff;
        g_vtot = vt; g_vs_on = vson; g_vs_off = vsoff; g_va_on = vaon; g_va_off = vaoff;
        h_end_cmp = lstate(ht - 1);
        hs_on_cmp = lstate(hson);   hs_off_cmp = lstate(hsoff);
        h_act_on_cmp = lstate(haon); h_act_off_cmp = lstate(haoff);
        v_end_cmp = lstate(vt);
        vs_on_cmp = lstate(vson);   vs_off_cmp = lstate(vsoff);
        v_act_on_cmp = lstate(vaon); v_act_off_cmp = lstate(vaoff);
    endtask

    task automatic pulse_load(string tag);
        mode_load = 1'b1;
        cmp_run(1, tag);
        mode_load = 1'b0;
    endtask

    task automatic check_val(bit cond, string tag, int act, int exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s act %0d exp %0d", tag, act, exp);
        end
    endtask

    // Cycles between successive rising pulses of line_start or frame_start.
    task automatic measure(bit frame, int exp, string tag);
        int cnt = 0;
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!(frame ? frame_start : line_start) && guard < 5000);
        do begin @(negedge clk); cnt++; end while (!(frame ? frame_start : line_start) && cnt < 5000);
        check_val(cnt == exp, tag, cnt, exp);
    endtask

    // R11: outputs while reset is held
    task automatic t_reset();
        set_geom(24, 1, 4, 8, 20, 10, 0, 2, 3, 8);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        nchk++;
        if ({hsync, vsync, disp_en, line_start, frame_start} != 5'b0) begin
            nerr++;
            $display("FAIL R11 reset outputs act %b exp 00000",
                     {hsync, vsync, disp_en, line_start, frame_start});
        end
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4 R5 R6 R7: geometry A, model comparison and periods
    task automatic t_geom_a();
        cmp_run(600, "R1_R4_R5_R6_R7 geomA");
        measure(1'b0, 24, "R2 line period A");
        measure(1'b1, 240, "R3 frame period A");
    endtask

    // R2 R3 R4 R5 R6: geometry B after a reload
    task automatic t_geom_b();
        set_geom(17, 1, 3, 5, 14, 7, 0, 1, 2, 6);
        pulse_load("R10 load B");
        cmp_run(400, "R4_R5_R6 geomB");
        measure(1'b0, 17, "R2 line period B");
        measure(1'b1, 119, "R3 frame period B");
    endtask

    // R8: blank mode keeps syncs low and line pulses running
    task automatic t_blank();
        int pulses = 0;
        int hs_seen = 0;
        blank_mode = 8'h01;
        for (int i = 0; i < 170; i++) begin
            @(negedge clk);
            if (i > 0) begin
                pulses += line_start;
                hs_seen += hsync | vsync | disp_en;
            end
        end
        check_val(hs_seen == 0, "R8 blank syncs quiet", hs_seen, 0);
        check_val(pulses == 9 || pulses == 10, "R8 line pulses continue", pulses, 10);
        blank_mode = 8'h23;
        cmp_run(60, "R8 other nonzero code");
        blank_mode = 8'h00;
        cmp_run(200, "R8 back to normal");
    endtask

    // R9: power-down latches until reload
    task automatic t_pwrdn();
        int act = 0;
        blank_mode = 8'h07;
        cmp_run(40, "R9 power-down");
        blank_mode = 8'h00;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            act += hsync | vsync | disp_en | line_start | frame_start;
        end
        check_val(act == 0, "R9 latch holds after code 0", act, 0);
        pulse_load("R10 leave power-down");
        cmp_run(300, "R10 restart after power-down");
    endtask

    // R10: reload in mid-frame restarts both counters
    task automatic t_midframe();
        cmp_run(77, "R10 pre-reload");
        pulse_load("R10 mid-frame");
        cmp_run(300, "R10 after mid-frame reload");
        measure(1'b1, 119, "R10 frame period after reload");
    endtask

    initial begin
        t_reset();
        t_geom_a();
        t_geom_b();
        t_blank();
        t_pwrdn();
        t_midframe();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog act running exp finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule